// File: doc/BRIEF.md
# Multi-Mode Iterative CORDIC Engine

This block is a fixed-point, iterative shift-and-add rotator. It has three datapaths, one each for x, y and z. One micro-rotation is done per clock. The block works in three coordinate systems: circular, linear and hyperbolic. In each system it runs either with the angle accumulator z driven toward zero (rotation) or with the y coordinate driven toward zero (vectoring). That gives six selectable operations in a single time-shared unit. It has no multiplier. Each step scales x and y by a power of two through variable arithmetic shifts, and a small per-system constant table supplies the z increment.

The x and y words use the Q2.13 two's complement format, where 1.0 is 8192. In circular operation, z is a scaled angle: pi maps to 32768, so a 16-bit z covers one full turn. In linear and hyperbolic operation, z is Q2.13. A client places the start values and the operation select on the inputs and pulses the start strobe. Busy is then held for the iteration count. The results appear together with a done flag and stay there until the next accepted start. In circular operation the growth of x and y is removed at the output by a fixed shift-add multiply. The hyperbolic growth is not compensated.

Top module: `tri_mode_cordic`

## Requirements
- R1: While reset is asserted and after it is released, busy_o and done_o are 0 and x_o, y_o and z_o are 0.
- R2: A start strobe sampled while idle loads the inputs. It raises busy_o and clears done_o from the next cycle. busy_o then stays high for exactly ITER cycles (12 by default). done_o rises in the cycle in which busy_o falls, and busy_o and done_o are never high together.
- R3: A start strobe that arrives while busy_o is high is ignored. The running operation finishes with the same results and timing as if the strobe had not come.
- R4: sys_i selects the coordinate system: 2'b00 is circular, 2'b01 is linear, and 2'b10 or 2'b11 is hyperbolic. vec_i=1 selects vectoring and vec_i=0 selects rotation.
- R5: Each micro-rotation with shift j and direction d in {+1,-1} computes three values. The new x is x - m*d*(x... y>>>j), with m=+1 for circular, 0 for linear and -1 for hyperbolic. The new y is y + d*(x>>>j). The new z is z - d*beta_j. In rotation, d=+1 when z>=0. In vectoring, d=+1 when y<0. x and y carry two guard bits internally, and z wraps in 16 bits.
- R6: The shift sequence is j=0,1,...,ITER-1 in circular and linear operation. In hyperbolic operation it starts at j=1, and the steps with j=4 and j=13 are each done twice before moving on.
- R7: beta_j is round(atan(2^-j)*32768/pi) in circular, 8192>>j in linear, and round(atanh(2^-j)*8192) in hyperbolic.
- R8: In circular operation, x_o and y_o are the low 16 bits of (v>>>1)+(v>>>3)-(v>>>6)-(v>>>9)-(v>>>13) applied to the internal x or y. In the other systems they are the low 16 bits of the internal value. z_o is always the internal z.
- R9: In linear operation x is never changed by an iteration, so x_o equals x_i at the end.
- R10: While done_o is high and no start arrives, done_o stays high and x_o, y_o and z_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| sys_i | input | 2 | Coordinate system select |
| vec_i | input | 1 | 1 selects vectoring, 0 selects rotation |
| x_i | input | 16 | Start value of x, Q2.13 |
| y_i | input | 16 | Start value of y, Q2.13 |
| z_i | input | 16 | Start value of z, scaled angle or Q2.13 |
| busy_o | output | 1 | Iterations in progress |
| done_o | output | 1 | Results valid |
| x_o | output | 16 | Final x |
| y_o | output | 16 | Final y |
| z_o | output | 16 | Final z |

## Verification
A behavioural model in the bench follows the update equations, the shift schedule and the constants computed with real-valued math. It is compared with busy, done and the results on every clock. The six operations are each driven with their own start values:
- A 45-degree rotation and a 3-4-5 vector separate the circular gain compensation from the raw datapath.
- A linear multiply and divide show that x is held.
- A hyperbolic rotation and a hyperbolic vectoring run, the latter selected by code 11, exercise the repeated shift steps.
- A negative-angle rotation exercises the direction choice on the sign.

Tolerance checks against closed-form values catch any fault that a shared misreading of the model could hide. A start strobe inserted mid-run and an idle wait after completion separate real ignoring and holding from mere reloading.

// File: rtl/tri_mode_cordic.sv
module tri_mode_cordic #(
  parameter int W     = 16,
  parameter int ITER  = 12,
  parameter int GUARD = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start_i,
  input  logic [1:0]   sys_i,
  input  logic         vec_i,
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic [W-1:0] z_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [W-1:0] x_o,
  output logic [W-1:0] y_o,
  output logic [W-1:0] z_o
);
  localparam int IW = W + GUARD;
  localparam int FB = W - 3;
  localparam int CW = $clog2(ITER + 1);
  localparam int SW = $clog2(ITER + 2) + 1;
  localparam logic [1:0]   SYS_CIRC = 2'b00;
  localparam logic [1:0]   SYS_LIN  = 2'b01;
  localparam logic [W-1:0] ONE      = W'(1) << FB;

  function automatic logic [W-1:0] beta_f(input logic [1:0] s, input logic [SW-1:0] j);
    logic [W-1:0] b;
    b = ONE >> j;
    if (s[1]) begin
      case (int'(j))
        1:  b = W'(4500);
        2:  b = W'(2092);
        3:  b = W'(1029);
        4:  b = W'(513);
        14: b = W'(1);
        default: b = ONE >> j;
      endcase
    end else if (s == SYS_CIRC) begin
      case (int'(j))
        0:  b = W'(8192);
        1:  b = W'(4836);
        2:  b = W'(2555);
        3:  b = W'(1297);
        4:  b = W'(651);
        5:  b = W'(326);
        6:  b = W'(163);
        7:  b = W'(81);
        8:  b = W'(41);
        9:  b = W'(20);
        10: b = W'(10);
        11: b = W'(5);
        12: b = W'(3);
        13: b = W'(1);
        14: b = W'(1);
        default: b = '0;
      endcase
    end
    return b;
  endfunction

  function automatic logic [W-1:0] comp_f(input logic signed [IW-1:0] v);
    logic signed [IW-1:0] s;
    s = (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 13);
    return W'(s);
  endfunction

  logic [1:0]           sys_q;
  logic                 vec_q, busy_q, done_q, rep_q;
  logic [CW-1:0]        cnt_q;
  logic [SW-1:0]        sh_q;
  logic signed [IW-1:0] x_q, y_q, xs, ys, x_n, y_n;
  logic signed [W-1:0]  z_q, z_n, beta;
  logic                 hyp, circ, lin, dpos, last, rep_hit;

  assign hyp  = sys_q[1];
  assign circ = (sys_q == SYS_CIRC);
  assign lin  = (sys_q == SYS_LIN);
  assign dpos = vec_q ? y_q[IW-1] : ~z_q[W-1];
  assign xs   = x_q >>> sh_q;
  assign ys   = y_q >>> sh_q;
  assign beta = $signed(beta_f(sys_q, sh_q));
  assign last = (cnt_q == CW'(ITER - 1));
  assign rep_hit = hyp && !rep_q && (sh_q == SW'(4) || sh_q == SW'(13));

  assign x_n = lin ? x_q : ((dpos ^ hyp) ? x_q - ys : x_q + ys);
  assign y_n = dpos ? y_q + xs : y_q - xs;
  assign z_n = dpos ? z_q - beta : z_q + beta;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sys_q  <= SYS_CIRC;
      vec_q  <= 1'b0;
      x_q    <= '0;
      y_q    <= '0;
      z_q    <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      rep_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (busy_q) begin
      x_q <= x_n;
      y_q <= y_n;
      z_q <= z_n;
      if (rep_hit) begin
        rep_q <= 1'b1;
      end else begin
        sh_q  <= sh_q + SW'(1);
        rep_q <= 1'b0;
      end
      if (last) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end else if (start_i) begin
      sys_q  <= sys_i;
      vec_q  <= vec_i;
      x_q    <= {{GUARD{x_i[W-1]}}, x_i};
      y_q    <= {{GUARD{y_i[W-1]}}, y_i};
      z_q    <= z_i;
      cnt_q  <= '0;
      sh_q   <= sys_i[1] ? SW'(1) : '0;
      rep_q  <= 1'b0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign x_o    = circ ? comp_f(x_q) : x_q[W-1:0];
  assign y_o    = circ ? comp_f(y_q) : y_q[W-1:0];
  assign z_o    = z_q;

  p_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && !busy_q) |=> (busy_q && !done_q));
  p_finish_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && last) |=> (done_q && !busy_q));
  p_ignore_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && start_i) |=> ($stable(sys_q) && $stable(vec_q)));
  p_hyp_shift_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && hyp) |-> (sh_q != '0));
  p_lin_x_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && lin) |=> $stable(x_q));
  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> (done_q && $stable(x_o) && $stable(y_o) && $stable(z_o)));
endmodule

// File: tb/tri_mode_cordic_tb.sv
module tri_mode_cordic_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int ITER = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic [1:0] sys_i = 2'b00;
  logic vec_i = 1'b0;
  logic [15:0] x_i = '0, y_i = '0, z_i = '0;
  logic busy_o, done_o;
  logic [15:0] x_o, y_o, z_o;

  int n_checks = 0;
  int n_err = 0;
  int cyc = 0;
  string tag_s = "R1 reset";

  int m_x = 0, m_y = 0, m_z = 0, m_cnt = 0, m_sh = 0, m_sys = 0;
  bit m_vec = 0, m_busy = 0, m_done = 0, m_rep = 0;

  tri_mode_cordic dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sys_i(sys_i), .vec_i(vec_i),
    .x_i(x_i), .y_i(y_i), .z_i(z_i), .busy_o(busy_o), .done_o(done_o),
    .x_o(x_o), .y_o(y_o), .z_o(z_o)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic int s16(int v);
    logic signed [15:0] t;
    t = 16'(v);
    return int'(t);
  endfunction

  function automatic int beta_m(int s, int j);
    real p;
    p = 1.0;
    for (int k = 0; k < j; k++) p = p / 2.0;
    if (s == 1) return 8192 >> j;
    if (s >= 2) return $rtoi($atanh(p) * 8192.0 + 0.5);
    return $rtoi($atan(p) * 32768.0 / 3.14159265358979 + 0.5);
  endfunction

  function automatic int comp_m(int v);
    return (v >>> 1) + (v >>> 3) - (v >>> 6) - (v >>> 9) - (v >>> 13);
  endfunction

  task automatic check(string t, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d", t, act, exp);
    end
  endtask

  task automatic near(string t, int act, int exp, int tol);
    n_checks++;
    if (act > exp + tol || act < exp - tol) begin
      n_err++;
      $display("FAIL %s: actual=%0d expected=%0d (+-%0d)", t, act, exp, tol);
    end
  endtask

  // reference model, one step per clock edge
  always @(posedge clk) begin
    bit d;
    int b, xs, ys, nx;
    if (!rst_n) begin
      m_x = 0; m_y = 0; m_z = 0; m_cnt = 0; m_sh = 0; m_sys = 0;
      m_vec = 0; m_busy = 0; m_done = 0; m_rep = 0;
    end else if (m_busy) begin
      d  = m_vec ? (m_y < 0) : (m_z >= 0);
      b  = beta_m(m_sys, m_sh);
      xs = m_x >>> m_sh;
      ys = m_y >>> m_sh;
      if (m_sys == 1) nx = m_x;
      else if (m_sys >= 2) nx = d ? m_x + ys : m_x - ys;
      else nx = d ? m_x - ys : m_x + ys;
      m_y = d ? m_y + xs : m_y - xs;
      m_z = s16(d ? m_z - b : m_z + b);
      m_x = nx;
      if (m_sys >= 2 && !m_rep && (m_sh == 4 || m_sh == 13)) m_rep = 1;
      else begin m_sh++; m_rep = 0; end
      m_cnt++;
      if (m_cnt == ITER) begin m_busy = 0; m_done = 1; end
    end else if (start_i) begin
      m_sys = int'(sys_i); m_vec = vec_i;
      m_x = int'($signed(x_i)); m_y = int'($signed(y_i)); m_z = int'($signed(z_i));
      m_cnt = 0; m_sh = (m_sys >= 2) ? 1 : 0; m_rep = 0;
      m_busy = 1; m_done = 0;
    end
  end

  // cycle-by-cycle comparison
  always @(negedge clk) begin
    if (rst_n) begin
      check({tag_s, " busy"}, int'(busy_o), int'(m_busy));
      check({tag_s, " done"}, int'(done_o), int'(m_done));
      if (m_done) begin
        check({tag_s, " x"}, int'($signed(x_o)), s16(m_sys == 0 ? comp_m(m_x) : m_x));
        check({tag_s, " y"}, int'($signed(y_o)), s16(m_sys == 0 ? comp_m(m_y) : m_y));
        check({tag_s, " z"}, int'($signed(z_o)), m_z);
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_err++;
      n_checks++;
      $display("FAIL watchdog: actual=%0d expected<=%0d cycles", cyc, 20000);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  task automatic run(int s, bit v, int x, int y, int z, string t, int poke);
    int nb;
    tag_s = t;
    @(negedge clk);
    sys_i = 2'(s); vec_i = v; x_i = 16'(x); y_i = 16'(y); z_i = 16'(z);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    nb = 0;
    while (!done_o && nb < ITER + 10) begin
      if (busy_o) nb++;
      if (poke > 0 && nb == poke) begin
        start_i = 1'b1; sys_i = 2'b01; vec_i = ~v;
        x_i = 16'h1234; y_i = 16'h0777; z_i = 16'h0100;
      end else begin
        start_i = 1'b0;
      end
      @(negedge clk);
    end
    start_i = 1'b0;
    check({t, " R2 busy cycles"}, nb, ITER);
  endtask

  initial begin
    int hx, hy, hz;
    repeat (3) @(negedge clk);
    check("R1 busy in reset", int'(busy_o), 0);
    check("R1 done in reset", int'(done_o), 0);
    check("R1 x in reset", int'(x_o), 0);
    check("R1 y in reset", int'(y_o), 0);
    check("R1 z in reset", int'(z_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 done after reset", int'(done_o), 0);

    run(0, 1'b0, 4000, 0, 8192, "R5 R7 R8 circular rotation", 0);
    near("R8 circular rotation x", int'($signed(x_o)), 2828, 12);
    near("R8 circular rotation y", int'($signed(y_o)), 2828, 12);
    near("R5 circular rotation z", int'($signed(z_o)), 0, 12);

    run(0, 1'b1, 3000, 4000, 0, "R5 R7 R8 circular vectoring", 0);
    near("R7 circular vectoring z", int'($signed(z_o)), 9672, 12);
    near("R8 circular vectoring x", int'($signed(x_o)), 5000, 12);
    near("R5 circular vectoring y", int'($signed(y_o)), 0, 12);

    run(1, 1'b0, 4096, 1000, 4096, "R5 R9 linear rotation", 0);
    check("R9 linear x held", int'($signed(x_o)), 4096);
    near("R5 linear rotation y", int'($signed(y_o)), 3048, 8);

    run(1, 1'b1, 8192, 4096, 0, "R5 R7 linear vectoring", 0);
    near("R7 linear vectoring z", int'($signed(z_o)), 4096, 8);
    check("R9 linear vectoring x held", int'($signed(x_o)), 8192);

    run(2, 1'b0, 8192, 0, 4000, "R6 R7 hyperbolic rotation", 0);
    near("R6 hyperbolic rotation z", int'($signed(z_o)), 0, 16);

    run(3, 1'b1, 8192, 4096, 0, "R4 R6 hyperbolic vectoring code 11", 0);
    near("R4 hyperbolic vectoring z", int'($signed(z_o)), 4500, 16);
    near("R6 hyperbolic vectoring y", int'($signed(y_o)), 0, 16);

    run(0, 1'b0, 5000, 2000, -12000, "R5 circular negative angle", 0);
    near("R5 negative angle z", int'($signed(z_o)), 0, 12);

    run(0, 1'b1, 3000, 4000, 0, "R3 start while busy", 4);
    near("R3 result unchanged z", int'($signed(z_o)), 9672, 12);
    near("R3 result unchanged x", int'($signed(x_o)), 5000, 12);

    tag_s = "R10 hold";
    hx = int'(x_o); hy = int'(y_o); hz = int'(z_o);
    repeat (6) @(negedge clk);
    check("R10 done held", int'(done_o), 1);
    check("R10 x held", int'(x_o), hx);
    check("R10 y held", int'(y_o), hy);
    check("R10 z held", int'(z_o), hz);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule